// File: doc/BRIEF.md
# 100 Mb/s Twisted-Pair Transmit Symbol Encoder

This block turns the 4-bit transmit nibbles that a MAC presents into the serial three-level line code used for 100 Mb/s twisted-pair transmission. Each nibble is mapped to a 5-bit code group. The group is shifted out one code bit per clock, scrambled against an 11-bit key stream, and then converted to a three-level (MLT3) output. The encoder also frames the stream. It fills the gaps between frames with idle groups, replaces the first two nibbles of a frame with the start delimiter pair, and appends the end delimiter pair when the MAC drops its valid strobe.

The MAC sees a request strobe once per five clocks. It must present the next nibble, valid and error flags during that strobe cycle; they are sampled at the closing clock edge. A control input can bypass the 4-bit to 5-bit mapping, in which case the error flag becomes the leading code bit. The bypass is honoured only when the mode input selects the wide (MII-style) MAC attachment. With the reduced-pin (RMII-style) attachment the mapping always stays active.

Top module: `txSymbolEncoder`

## Requirements
- R1: While reset (active low, asynchronous) is held, the line level is 0 (code 2'b00) and the request strobe is low. The first group sent after reset is idle, and the scrambler starts from the seed 11'h7FF.
- R2: One code bit leaves per clock. Each group goes out most significant bit first. The request strobe is high in exactly one cycle out of five, starting in the fifth cycle after reset release. Inputs are sampled at the edge that ends that cycle, and the first bit of the group they select affects the line level after the next edge.
- R3: During frame data, a nibble maps to a group as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R4: When valid is low and no frame is in progress, the group is idle (11111). When valid is seen high with no frame in progress, the next two groups are the start pair 11000 and then 10001, and the two nibbles offered are dropped. When valid is seen low during data, the end pair 01101 and then 00111 is sent, with the inputs offered for the second group ignored, and the encoder returns to idle.
- R5: During frame data, an asserted error flag replaces the nibble's group with the halt group 00100.
- R6: With the mode input high (MII-style) and the mapping-enable input low, each group is {error flag, nibble[3:0]} regardless of valid. Framing is suspended, and after leaving bypass the encoder starts from idle.
- R7: With the mode input low (RMII-style), the mapping-enable input has no effect: groups follow R3, R4 and R5.
- R8: Each clock the scrambler key is bit 10 XOR bit 8 of an 11-bit register. The register shifts left by one, taking the key in at bit 0, and the bit driven to the level encoder is the code bit XOR the key.
- R9: The line level steps through 0, +1, 0, -1 in that order. A scrambled bit of 1 advances it one step, and a 0 holds it. Levels are coded 0=2'b00, +1=2'b01, -1=2'b11, and 2'b10 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Code-bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txNibble | input | 4 | Transmit nibble from the MAC |
| txValid | input | 1 | Frame valid from the MAC |
| txErr | input | 1 | Transmit error from the MAC |
| codecOn | input | 1 | 1 = 4B/5B mapping on; 0 requests bypass |
| miiMode | input | 1 | 1 = MII-style attachment, 0 = RMII-style |
| nibbleReq | output | 1 | High in the cycle whose closing edge samples the inputs |
| mlt3Level | output | 2 | Signed three-level line output |

## Verification
Inputs offered during a request cycle select a group that is loaded at that cycle's closing edge. The line level then shows that group's first bit one edge later, and its fifth bit at the next load edge. The bench therefore walks the stream one group at a time. It drives a group's inputs on the falling edge inside the request cycle and checks the request strobe on every falling edge. After each of the following five rising edges it compares the level with a reference. That reference follows the scrambler and level rules from a known reset point, so each expected group is checked bit by bit at the level output.

// File: rtl/txEncPkg.sv
package txEncPkg;

  localparam int NIB_W = 4;
  localparam int GRP_W = 5;

  typedef enum logic [2:0] {
    SEL_IDLE, SEL_J, SEL_K, SEL_T, SEL_R, SEL_HALT, SEL_DATA, SEL_RAW
  } grpSel_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_K, ST_DATA, ST_R
  } frameSt_e;

  typedef struct packed {
    logic    loadGroup;
    grpSel_e sel;
  } txStrobe_t;

  localparam logic [GRP_W-1:0] GRP_IDLE = 5'b11111;
  localparam logic [GRP_W-1:0] GRP_J    = 5'b11000;
  localparam logic [GRP_W-1:0] GRP_K    = 5'b10001;
  localparam logic [GRP_W-1:0] GRP_T    = 5'b01101;
  localparam logic [GRP_W-1:0] GRP_R    = 5'b00111;
  localparam logic [GRP_W-1:0] GRP_HALT = 5'b00100;

  function automatic logic [GRP_W-1:0] map4b5b(input logic [NIB_W-1:0] nib);
    logic [GRP_W-1:0] g;
    case (nib)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/txScrambler.sv
module txScrambler #(
  parameter int LEN = 11,
  parameter int TAP_HI = 11,
  parameter int TAP_LO = 9,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic clk,
  input  logic rstN,
  output logic key
);
  logic [LEN-1:0] lfsrQ;

  always_comb key = lfsrQ[TAP_HI-1] ^ lfsrQ[TAP_LO-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= SEED;
    else       lfsrQ <= {lfsrQ[LEN-2:0], key};
  end
endmodule

// File: rtl/txFrameCtrl.sv
module txFrameCtrl
  import txEncPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txValid,
  input  logic       txErr,
  input  logic       codecOn,
  input  logic       miiMode,
  output logic       nibbleReq,
  output txStrobe_t  strobe
);
  localparam int CNT_W = $clog2(GRP_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GRP_W - 1);

  logic [CNT_W-1:0] bitIdx;
  frameSt_e stQ, stNext;
  logic bypass;
  grpSel_e selNext;

  always_comb begin
    nibbleReq = (bitIdx == LAST_IDX);
    bypass    = miiMode & ~codecOn;
    stNext    = stQ;
    selNext   = SEL_IDLE;
    if (bypass) begin
      selNext = SEL_RAW;
      stNext  = ST_IDLE;
    end else begin
      case (stQ)
        ST_IDLE: begin
          if (txValid) begin
            selNext = SEL_J;
            stNext  = ST_K;
          end
        end
        ST_K: begin
          selNext = SEL_K;
          stNext  = ST_DATA;
        end
        ST_DATA: begin
          if (!txValid) begin
            selNext = SEL_T;
            stNext  = ST_R;
          end else begin
            selNext = txErr ? SEL_HALT : SEL_DATA;
          end
        end
        default: begin
          selNext = SEL_R;
          stNext  = ST_IDLE;
        end
      endcase
    end
    strobe.loadGroup = nibbleReq;
    strobe.sel       = selNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= '0;
      stQ    <= ST_IDLE;
    end else if (nibbleReq) begin
      bitIdx <= '0;
      stQ    <= stNext;
    end else begin
      bitIdx <= bitIdx + 1'b1;
    end
  end
endmodule

// File: rtl/txLineDatapath.sv
module txLineDatapath
  import txEncPkg::*;
#(
  parameter int LFSR_LEN = 11,
  parameter int TAP_HI = 11,
  parameter int TAP_LO = 9,
  parameter logic [LFSR_LEN-1:0] LFSR_SEED = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  input  logic [NIB_W-1:0] txNibble,
  input  logic             txErr,
  output logic             scrBit,
  output logic [1:0]       lineLevel
);
  logic [GRP_W-1:0] shiftQ, grpNext;
  logic [1:0] phaseQ;
  logic key;

  txScrambler #(
    .LEN(LFSR_LEN), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(LFSR_SEED)
  ) uScr (
    .clk(clk), .rstN(rstN), .key(key)
  );

  always_comb begin
    case (strobe.sel)
      SEL_J:    grpNext = GRP_J;
      SEL_K:    grpNext = GRP_K;
      SEL_T:    grpNext = GRP_T;
      SEL_R:    grpNext = GRP_R;
      SEL_HALT: grpNext = GRP_HALT;
      SEL_DATA: grpNext = map4b5b(txNibble);
      SEL_RAW:  grpNext = {txErr, txNibble};
      default:  grpNext = GRP_IDLE;
    endcase
  end

  always_comb scrBit = shiftQ[GRP_W-1] ^ key;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= GRP_IDLE;
      phaseQ <= '0;
    end else begin
      shiftQ <= strobe.loadGroup ? grpNext : {shiftQ[GRP_W-2:0], 1'b0};
      phaseQ <= phaseQ + {1'b0, scrBit};
    end
  end

  always_comb begin
    case (phaseQ)
      2'd1:    lineLevel = 2'b01;
      2'd3:    lineLevel = 2'b11;
      default: lineLevel = 2'b00;
    endcase
  end
endmodule

// File: rtl/txSymbolEncoder.sv
module txSymbolEncoder
  import txEncPkg::*;
#(
  parameter int LFSR_LEN = 11,
  parameter int TAP_HI = 11,
  parameter int TAP_LO = 9,
  parameter logic [LFSR_LEN-1:0] LFSR_SEED = 11'h7FF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] txNibble,
  input  logic             txValid,
  input  logic             txErr,
  input  logic             codecOn,
  input  logic             miiMode,
  output logic             nibbleReq,
  output logic [1:0]       mlt3Level
);
  txStrobe_t strobe;
  logic scrBit;

  txFrameCtrl uCtrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txErr(txErr),
    .codecOn(codecOn), .miiMode(miiMode),
    .nibbleReq(nibbleReq), .strobe(strobe)
  );

  txLineDatapath #(
    .LFSR_LEN(LFSR_LEN), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .LFSR_SEED(LFSR_SEED)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txNibble(txNibble),
    .txErr(txErr), .scrBit(scrBit), .lineLevel(mlt3Level)
  );
endmodule

// File: rtl/txSymbolEncoderChk.sv
module txSymbolEncoderChk (
  input logic       clk,
  input logic       rstN,
  input logic       nibbleReq,
  input logic       scrBit,
  input logic [1:0] mlt3Level
);
  logic [2:0] sinceReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sinceReq <= '0;
    else if (nibbleReq) sinceReq <= '0;
    else                sinceReq <= sinceReq + 1'b1;
  end

  // R9: the unused level code never appears
  a_r9_legal_level: assert property (@(posedge clk) disable iff (!rstN)
    mlt3Level != 2'b10);

  // R9: a scrambled 0 holds the level
  a_r9_hold_on_zero: assert property (@(posedge clk) disable iff (!rstN)
    !scrBit |=> $stable(mlt3Level));

  // R9: a scrambled 1 moves the level
  a_r9_move_on_one: assert property (@(posedge clk) disable iff (!rstN)
    scrBit |=> !$stable(mlt3Level));

  // R9: a non-zero level is always followed by itself or by 0
  a_r9_via_zero: assert property (@(posedge clk) disable iff (!rstN)
    (mlt3Level != 2'b00) |=> (mlt3Level == $past(mlt3Level) || mlt3Level == 2'b00));

  // R2: request strobe lasts one cycle
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rstN)
    nibbleReq |=> !nibbleReq);

  // R2: request strobe arrives every fifth cycle
  a_r2_req_period: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReq == 3'd4) == nibbleReq);
endmodule

bind txSymbolEncoder txSymbolEncoderChk uChk (
  .clk(clk), .rstN(rstN), .nibbleReq(nibbleReq),
  .scrBit(uPath.scrBit), .mlt3Level(mlt3Level)
);

// File: tb/tb_txSymbolEncoder.sv
module tb_txSymbolEncoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] txNibble = 4'h0;
  logic txValid = 1'b0, txErr = 1'b0, codecOn = 1'b1, miiMode = 1'b0;
  logic nibbleReq;
  logic [1:0] mlt3Level;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int reqErr = 0;

  logic [10:0] mLfsr;
  logic [1:0]  mPhase;
  logic [4:0]  curExp;

  always #5 clk = ~clk;

  txSymbolEncoder dut (
    .clk(clk), .rstN(rstN), .txNibble(txNibble), .txValid(txValid),
    .txErr(txErr), .codecOn(codecOn), .miiMode(miiMode),
    .nibbleReq(nibbleReq), .mlt3Level(mlt3Level)
  );

  // fields: tag[16:13] valid[12] err[11] nib[10:7] codecOn[6] miiMode[5] expected group[4:0]
  localparam int NV = 30;
  localparam logic [16:0] VEC [NV] = '{
    {4'd4, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 5'b11111},  // R4 idle
    {4'd4, 1'b1, 1'b0, 4'h5, 1'b1, 1'b0, 5'b11000},  // R4 J
    {4'd4, 1'b1, 1'b0, 4'h5, 1'b1, 1'b0, 5'b10001},  // R4 K
    {4'd3, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 5'b11110},  // R3
    {4'd3, 1'b1, 1'b0, 4'h7, 1'b1, 1'b0, 5'b01111},  // R3
    {4'd3, 1'b1, 1'b0, 4'hA, 1'b1, 1'b0, 5'b10110},  // R3
    {4'd3, 1'b1, 1'b0, 4'hF, 1'b1, 1'b0, 5'b11101},  // R3
    {4'd5, 1'b1, 1'b1, 4'h3, 1'b1, 1'b0, 5'b00100},  // R5 halt
    {4'd3, 1'b1, 1'b0, 4'h9, 1'b1, 1'b0, 5'b10011},  // R3
    {4'd4, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 5'b01101},  // R4 T
    {4'd4, 1'b1, 1'b0, 4'h4, 1'b1, 1'b0, 5'b00111},  // R4 R, valid ignored
    {4'd4, 1'b1, 1'b0, 4'h2, 1'b1, 1'b0, 5'b11000},  // R4 J
    {4'd4, 1'b1, 1'b0, 4'h2, 1'b1, 1'b0, 5'b10001},  // R4 K
    {4'd4, 1'b0, 1'b0, 4'h2, 1'b1, 1'b0, 5'b01101},  // R4 T right after K
    {4'd4, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 5'b00111},  // R4 R
    {4'd4, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 5'b11111},  // R4 idle
    {4'd7, 1'b0, 1'b0, 4'h3, 1'b0, 1'b0, 5'b11111},  // R7 bypass request ignored
    {4'd7, 1'b1, 1'b0, 4'hC, 1'b0, 1'b0, 5'b11000},  // R7
    {4'd7, 1'b1, 1'b0, 4'hC, 1'b0, 1'b0, 5'b10001},  // R7
    {4'd7, 1'b1, 1'b0, 4'hC, 1'b0, 1'b0, 5'b11010},  // R7 still mapped
    {4'd6, 1'b1, 1'b1, 4'h6, 1'b0, 1'b1, 5'b10110},  // R6 raw, err leads
    {4'd6, 1'b0, 1'b0, 4'h3, 1'b0, 1'b1, 5'b00011},  // R6 raw, valid low
    {4'd6, 1'b1, 1'b0, 4'hE, 1'b0, 1'b1, 5'b01110},  // R6 raw
    {4'd6, 1'b1, 1'b0, 4'h1, 1'b1, 1'b1, 5'b11000},  // R6 restart from idle
    {4'd4, 1'b1, 1'b0, 4'h1, 1'b1, 1'b1, 5'b10001},  // R4 K
    {4'd3, 1'b1, 1'b0, 4'h8, 1'b1, 1'b1, 5'b10010},  // R3
    {4'd3, 1'b1, 1'b0, 4'hD, 1'b1, 1'b1, 5'b11011},  // R3
    {4'd4, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 5'b01101},  // R4 T
    {4'd4, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 5'b00111},  // R4 R
    {4'd4, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 5'b11111}   // R4 idle
  };

  function automatic logic [1:0] lvlOf(input logic [1:0] ph);
    return (ph == 2'd1) ? 2'b01 : (ph == 2'd3) ? 2'b11 : 2'b00;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mLfsr = 11'h7FF;  // R1 seed
    mPhase = 2'd0;
    curExp = 5'b11111;
  endtask

  // Sends the current group (curExp) and offers the inputs of the next one.
  task automatic step(input logic v, input logic e, input logic [3:0] n,
                      input logic c, input logic m, input logic [4:0] nextExp,
                      input string tag);
    logic [9:0] actSeq, expSeq;
    actSeq = '0;
    expSeq = '0;
    for (int i = 0; i < 5; i++) begin
      if (nibbleReq !== (i == 4)) reqErr++;
      if (i == 4) begin
        txValid = v; txErr = e; txNibble = n; codecOn = c; miiMode = m;
      end
      @(posedge clk);
      begin
        logic key, sb;
        key = mLfsr[10] ^ mLfsr[8];  // R8
        sb = curExp[4-i] ^ key;
        mLfsr = {mLfsr[9:0], key};
        if (sb) mPhase = mPhase + 2'd1;  // R9
      end
      @(negedge clk);
      actSeq = {actSeq[7:0], mlt3Level};
      expSeq = {expSeq[7:0], lvlOf(mPhase)};
    end
    check(actSeq == expSeq, tag, {22'd0, actSeq}, {22'd0, expSeq});
    curExp = nextExp;
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    check(mlt3Level == 2'b00, "R1 level in reset", {30'd0, mlt3Level}, 0);
    check(nibbleReq == 1'b0, "R1 request in reset", {31'd0, nibbleReq}, 0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [16:0] w;
      w = VEC[k];
      step(w[12], w[11], w[10:7], w[6], w[5], w[4:0],
           $sformatf("R%0d group %0d (R8 R9 line path)", w[16:13], k));
    end
    step(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 5'b11000, "R4 idle flush");
    check(reqErr == 0, "R2 request strobe cadence", reqErr, 0);

    // R1: reset in the middle of a frame restores level 0 and an idle, freshly seeded stream
    step(1'b1, 1'b0, 4'h6, 1'b1, 1'b0, 5'b10001, "R4 J before reset");
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(mlt3Level == 2'b00, "R1 level after mid-frame reset", {30'd0, mlt3Level}, 0);
    check(nibbleReq == 1'b0, "R1 request after mid-frame reset", {31'd0, nibbleReq}, 0);
    @(negedge clk);
    txValid = 1'b0;
    modelReset();
    rstN = 1'b1;
    reqErr = 0;
    step(1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 5'b11111, "R1 first group idle after reset");
    step(1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 5'b11111, "R1 idle continues");
    check(reqErr == 0, "R2 request cadence after reset", reqErr, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule